// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synchronous static memory with a 32-bit word made of four byte lanes. Its address width is set by a parameter. Its control side follows the usual processor-bus burst memory. An address is taken in by either of two strobes: one driven by the processor and one driven by a memory controller. Three chip-select inputs are checked only when a new address is taken. An internal 2-bit counter then steps through the four words of a burst on request. Read data is flow-through: the word at the registered address appears on the output in the same cycle that follows the edge which set the address, with no further pipeline register.

Writes come in two kinds. A whole-word write command stores all four lanes. A lane write command stores only the lanes whose select is low. The data bus is split into a write-data input and a read-data output. A drive flag replaces the bidirectional pins, and it is formed asynchronously from the output-enable input. A sleep input freezes every piece of state and keeps the array contents.

Top module: `fts_burst_sram`

## Requirements
- R1: After synchronous reset the block is deselected and `rdata_drive` is 0.
- R2: On a rising edge where `ctrl_strobe_n` is 0, or `proc_strobe_n` and `sel1_n` are both 0, `addr_i` is loaded as the current address. The select state becomes (`sel1_n`==0 && `sel2`==1 && `sel3_n`==0).
- R3: When both strobes are 0 in one cycle, the processor strobe takes precedence. A processor-strobe cycle never writes, whatever the write inputs are.
- R4: `proc_strobe_n` has no effect while `sel1_n` is 1, so the address and select state are kept. `ctrl_strobe_n` still loads in that case, and it deselects the block.
- R5: The chip selects are examined only on a load edge. In other cycles the select state is held.
- R6: While selected, with `advance_n` at 0 and no load, the low two address bits increment modulo 4 (for example 14,15,12,13). The upper bits stay fixed. With no strobe and no advance, the address is held.
- R7: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R8: With `all_wr_n`=1 and `lane_wr_n`=0, lane k (bits 8k+7:8k) is written only where `lane_sel_n[k]`=0. With `lane_wr_n`=1, nothing is written.
- R9: `rdata` shows the word at the address set by the previous rising edge, in the cycle right after that edge. A write targets the newly loaded, advanced or held address and uses the `wdata` present at that edge.
- R10: `rdata_drive` is 0 whenever `out_en_n` is 1, and follows `out_en_n` with no clock edge.
- R11: In the first cycle after a load that moves the block from deselected to selected, `rdata_drive` stays 0.
- R12: While `sleep` is 1, no write happens, address and select state are frozen, and `rdata_drive` is 0. The contents survive.
- R13: When deselected, no write happens. In the cycle after a write edge, `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-activity retention mode, active high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Flow-through read data |
| rdata_drive | output | 1 | High when read data would be driven |

## Verification
The bench targets four behaviours that are easy to get wrong.

- **Burst wrap.** The burst must wrap inside its four-word group. An adder that carries into the upper bits would read address 16 instead of 12.
- **Strobe priority.** A cycle with both strobes low must not write. A design that lets the controller strobe win would overwrite the word.
- **Chip-select gating.** The processor strobe with select 1 high must be ignored. Chip-select changes in a non-load cycle must not deselect the block. A design that samples selects every cycle would drop the output. A write attempted while deselected must leave the word intact.
- **Output masking and sleep.** The drive flag must stay off on the first read after deselect and during sleep. Sleep must leave the held address and all contents unchanged.

// File: rtl/fsram_pkg.sv
package fsram_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef logic [LANES-1:0]  lane_vec_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic load;       // an address is taken this edge
        logic from_proc;  // taken by the processor strobe
        logic sel_new;    // select state after this edge
    } capture_t;

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] c);
        return c + 1'b1;
    endfunction

    function automatic lane_vec_t lane_enables(input logic all_n, input logic byte_n,
                                               input lane_vec_t sel_n);
        if (!all_n)       return '1;
        else if (!byte_n) return ~sel_n;
        else              return '0;
    endfunction
endpackage

// File: rtl/fsram_addr_ctl.sv
module fsram_addr_ctl
    import fsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [AW-1:0] addr_i,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          advance_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    output capture_t      cap,
    output logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] cur_addr,
    output logic          sel_q,
    output logic          first_q
);
    always_comb begin
        cap.from_proc = !proc_strobe_n && !sel1_n;
        cap.load      = cap.from_proc || !ctrl_strobe_n;
        cap.sel_new   = cap.load ? (!sel1_n && sel2 && !sel3_n) : sel_q;
        if (cap.load)
            tgt_addr = addr_i;
        else if (!advance_n && sel_q)
            tgt_addr = {cur_addr[AW-1:BURST_W], burst_step(cur_addr[BURST_W-1:0])};
        else
            tgt_addr = cur_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            sel_q    <= 1'b0;
            first_q  <= 1'b0;
        end else if (!hold) begin
            cur_addr <= tgt_addr;
            sel_q    <= cap.sel_new;
            first_q  <= cap.load && cap.sel_new && !sel_q;
        end
    end
endmodule

// File: rtl/fsram_write_dec.sv
module fsram_write_dec
    import fsram_pkg::*;
(
    input  logic      enable,
    input  logic      all_wr_n,
    input  logic      lane_wr_n,
    input  lane_vec_t lane_sel_n,
    output lane_vec_t lane_we
);
    lane_vec_t mask;
    assign mask = lane_enables(all_wr_n, lane_wr_n, lane_sel_n);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = enable && mask[g];
    end
endmodule

// File: rtl/fsram_lane_array.sv
module fsram_lane_array
    import fsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  lane_vec_t     lane_we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
    import fsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          advance_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          all_wr_n,
    input  logic          lane_wr_n,
    input  logic [3:0]    lane_sel_n,
    input  logic          out_en_n,
    input  logic          sleep,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          rdata_drive
);
    capture_t      cap;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] cur_addr;
    logic          sel_q;
    logic          first_q;
    logic          wrote_q;
    lane_vec_t     lane_we;
    logic          wr_allow;

    fsram_addr_ctl #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .hold(sleep), .addr_i(addr_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .cap(cap), .tgt_addr(tgt_addr), .cur_addr(cur_addr),
        .sel_q(sel_q), .first_q(first_q)
    );

    assign wr_allow = cap.sel_new && !cap.from_proc && !sleep;

    fsram_write_dec u_wdec (
        .enable(wr_allow), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .lane_we(lane_we)
    );

    fsram_lane_array #(.AW(AW)) u_array (
        .clk(clk), .lane_we(lane_we), .waddr(tgt_addr), .wdata(wdata),
        .raddr(cur_addr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)         wrote_q <= 1'b0;
        else if (!sleep) wrote_q <= |lane_we;
    end

    assign rdata_drive = !out_en_n && !sleep && sel_q && !first_q && !wrote_q;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          sleep,
    input logic          proc_strobe_n,
    input logic          ctrl_strobe_n,
    input logic          advance_n,
    input logic          sel1_n,
    input logic          all_wr_n,
    input logic          out_en_n,
    input logic          rdata_drive,
    input logic [AW-1:0] cur_addr,
    input logic          sel_q,
    input logic [3:0]    lane_we
);
    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);

    assert_sleep_nowrite_R12: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (lane_we == 4'h0 && !rdata_drive));

    assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(cur_addr) && $stable(sel_q));

    assert_proc_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !proc_strobe_n && sel1_n && ctrl_strobe_n && advance_n)
        |=> $stable(cur_addr) && $stable(sel_q));

    assert_first_mask_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> !rdata_drive);

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!sleep && sel_q && !advance_n && proc_strobe_n && ctrl_strobe_n)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)
            && (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    assert_all_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        (!sleep && sel_q && !all_wr_n && proc_strobe_n && ctrl_strobe_n)
        |-> lane_we == 4'hF);

    assert_desel_nowrite_R13: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && proc_strobe_n && ctrl_strobe_n) |-> lane_we == 4'h0);
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .sel1_n(sel1_n),
    .all_wr_n(all_wr_n), .out_en_n(out_en_n), .rdata_drive(rdata_drive),
    .cur_addr(cur_addr), .sel_q(sel_q), .lane_we(lane_we)
);

// File: tb/test_fts_burst_sram.sv
module test_fts_burst_sram;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, advance_n = 1'b1;
    logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic          all_wr_n = 1'b1, lane_wr_n = 1'b1, out_en_n = 1'b0, sleep = 1'b0;
    logic [3:0]    lane_sel_n = 4'hF;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rdata_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fts_burst_sram #(.AW(AW)) i_fts_burst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
        .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        out_en_n = 1'b0; sleep = 1'b0;
    endtask

    task automatic ctrl_write(input logic [AW-1:0] a, input logic [31:0] d);
        idle(); ctrl_strobe_n = 1'b0; addr_i = a; all_wr_n = 1'b0; wdata = d;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        idle(); rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        check("R1 drive after reset", {31'd0, rdata_drive}, 32'd0);
    endtask

    task automatic t_first_access();
        ctrl_write(6'd3, 32'hDEADBEEF);
        check("R13 drive after write", {31'd0, rdata_drive}, 32'd0);
        cyc();
        check("R2 drive after load", {31'd0, rdata_drive}, 32'd1);
        check("R7 word written", rdata, 32'hDEADBEEF);
        idle(); ctrl_strobe_n = 1'b0; sel2 = 1'b0; addr_i = 6'd0;
        cyc();
        check("R2 deselect by load", {31'd0, rdata_drive}, 32'd0);
        idle(); ctrl_strobe_n = 1'b0; addr_i = 6'd3;
        cyc();
        check("R11 first read masked", {31'd0, rdata_drive}, 32'd0);
        check("R9 data ready after load edge", rdata, 32'hDEADBEEF);
        idle();
        cyc();
        check("R11 drive on second cycle", {31'd0, rdata_drive}, 32'd1);
    endtask

    task automatic t_burst();
        ctrl_write(6'd12, 32'hC0DE0000);
        for (int k = 1; k < 4; k++) begin
            advance_n = 1'b0; all_wr_n = 1'b0; wdata = 32'hC0DE0000 + k;
            cyc();
        end
        idle(); proc_strobe_n = 1'b0; addr_i = 6'd14;
        cyc();
        check("R9 burst read start", rdata, 32'hC0DE0002);
        check("R3 proc load drives", {31'd0, rdata_drive}, 32'd1);
        idle(); advance_n = 1'b0;
        cyc(); check("R6 step to 15", rdata, 32'hC0DE0003);
        cyc(); check("R6 wrap to 12", rdata, 32'hC0DE0000);
        cyc(); check("R6 step to 13", rdata, 32'hC0DE0001);
        idle();
        cyc(); check("R6 hold without advance", rdata, 32'hC0DE0001);
    endtask

    task automatic t_lanes();
        ctrl_write(6'd20, 32'hAAAAAAAA);
        lane_wr_n = 1'b0; lane_sel_n = 4'b1010; wdata = 32'h11223344;
        cyc();
        idle(); lane_wr_n = 1'b1; lane_sel_n = 4'h0; wdata = 32'h55555555;
        cyc();
        check("R8 selected lanes only", rdata, 32'hAA22AA44);
        check("R13 drive back after write", {31'd0, rdata_drive}, 32'd1);
        idle();
        cyc();
        check("R8 no write when lane enable high", rdata, 32'hAA22AA44);
        all_wr_n = 1'b0; lane_wr_n = 1'b0; lane_sel_n = 4'b1110; wdata = 32'h0BADF00D;
        cyc();
        idle();
        cyc();
        check("R7 whole word overrides lanes", rdata, 32'h0BADF00D);
    endtask

    task automatic t_priority();
        ctrl_write(6'd30, 32'h30303030);
        cyc();
        proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr_i = 6'd30;
        all_wr_n = 1'b0; wdata = 32'hFFFFFFFF;
        cyc();
        check("R3 no write in proc cycle", rdata, 32'h30303030);
        check("R3 drive in proc cycle", {31'd0, rdata_drive}, 32'd1);
    endtask

    task automatic t_proc_gate();
        idle(); proc_strobe_n = 1'b0; sel1_n = 1'b1; addr_i = 6'd3;
        cyc();
        check("R4 proc ignored address", rdata, 32'h30303030);
        check("R4 proc ignored select", {31'd0, rdata_drive}, 32'd1);
        idle(); ctrl_strobe_n = 1'b0; sel1_n = 1'b1; addr_i = 6'd3;
        cyc();
        check("R4 ctrl loads and deselects", {31'd0, rdata_drive}, 32'd0);
    endtask

    task automatic t_select_sample();
        idle(); all_wr_n = 1'b0; wdata = 32'h12345678;
        cyc();
        check("R5 no reselect without load", {31'd0, rdata_drive}, 32'd0);
        idle(); ctrl_strobe_n = 1'b0; addr_i = 6'd3;
        cyc();
        idle();
        cyc();
        check("R13 deselected write blocked", rdata, 32'hDEADBEEF);
        sel1_n = 1'b1; sel2 = 1'b0;
        cyc();
        check("R5 selects ignored off load", {31'd0, rdata_drive}, 32'd1);
        idle();
    endtask

    task automatic t_oe_async();
        out_en_n = 1'b1; #1;
        check("R10 oe high disables", {31'd0, rdata_drive}, 32'd0);
        out_en_n = 1'b0; #1;
        check("R10 oe low enables", {31'd0, rdata_drive}, 32'd1);
    endtask

    task automatic t_sleep();
        sleep = 1'b1; #1;
        check("R12 drive off in sleep", {31'd0, rdata_drive}, 32'd0);
        ctrl_strobe_n = 1'b0; addr_i = 6'd30; all_wr_n = 1'b0; wdata = 32'h0;
        cyc();
        ctrl_strobe_n = 1'b1; advance_n = 1'b0;
        cyc();
        idle(); #1;
        check("R12 address kept", rdata, 32'hDEADBEEF);
        check("R12 select kept", {31'd0, rdata_drive}, 32'd1);
        ctrl_strobe_n = 1'b0; addr_i = 6'd30;
        cyc();
        idle();
        check("R12 contents kept", rdata, 32'h30303030);
    endtask

    initial begin
        t_reset();
        t_first_access();
        t_burst();
        t_lanes();
        t_priority();
        t_proc_gate();
        t_select_sample();
        t_oe_async();
        t_sleep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule